// File: doc/BRIEF.md
# Two-Stage PWM Rate Generator

This block derives timing enables for a set of PWM channels from one master clock. A free-running binary prescaler gives eleven tap rates: the master clock divided by 1, 2, 4 and so on up to 1024. Two independent linear dividers, A and B, each pick one of those taps and divide it again by an 8-bit integer from 1 to 255. A divide value of zero turns that divider off.

Every output is a one-cycle clock-enable pulse in the master clock domain. No derived clock is generated. Channels choose among the eleven tap enables and the two divider enables, and advance only on cycles where their chosen enable is high.

The select and divide fields come straight from a configuration register outside the block. Each divider keeps a shadow copy of its two fields. The shadow is cleared by reset, so both dividers are off after reset. When a field differs from its shadow, the divider reloads it and restarts its count. There is no streaming data path, so all pins are plain control and status pins with no handshake.

Top module: `pwm_rate_gen`

## Requirements
- R1: Bit k of `tap_en` (k = 0 to 10) pulses for one cycle every 2^k master cycles. Bit 0 is high on every cycle out of reset.
- R2: The taps are nested. On any cycle where bit k of `tap_en` is high, every lower bit is also high.
- R3: For a select value S from 0 to 10 and a divide value D from 1 to 255, the divider output pulses once every D * 2^S cycles in steady state. Each of its pulses falls on a cycle where tap S pulses.
- R4: A divide value of 0 keeps that divider's output low on every cycle.
- R5: Select values 11 to 15 are reserved and select no tap. The divider's output then stays low, whatever the divide value.
- R6: While `rst` is high, all outputs are low. Reset clears both dividers' stored settings and the prescaler count. On the first cycle after reset, with fields at zero, all eleven taps are high and `en_a` and `en_b` are low.
- R7: A cycle in which a divider's select or divide input differs from its stored value produces no pulse on that divider, and the divider's count restarts. With S = 0, the first pulse comes exactly D cycles after the cycle in which the new value was applied.
- R8: Dividers A and B are independent. Each keeps its own period when both run at the same time with different settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_a | input | 4 | Tap select for divider A (0 to 10 valid) |
| div_a | input | 8 | Divide value for divider A (0 = off) |
| sel_b | input | 4 | Tap select for divider B (0 to 10 valid) |
| div_b | input | 8 | Divide value for divider B (0 = off) |
| tap_en | output | 11 | Prescaler enables; bit k pulses at master/2^k |
| en_a | output | 1 | Divider A enable pulse |
| en_b | output | 1 | Divider B enable pulse |

## Verification
Two events can meet in one cycle: a change of configuration and a selected tap pulse that would otherwise complete a divider count. The bench provokes this with select 0, so the tap is high on every cycle, and writes a new divide value while the divider is running. The change must win in that cycle: the output is sampled right after the write and must be low. The first pulse must then come exactly at the new divide count, which confirms that the old partial count was discarded and not merged with the new one.

// File: rtl/pwm_rate_pkg.sv
package pwm_rate_pkg;
  localparam int PWM_TAPS  = 11;  // divide by 2^0 .. 2^10
  localparam int PWM_SEL_W = 4;
  localparam int PWM_DIV_W = 8;
  localparam int PWM_NDIV  = 2;   // dividers A and B
endpackage

// File: rtl/pwm_tap_counter.sv
// Free-running binary prescaler. Tap k is high when the low k count bits are all zero.
module pwm_tap_counter #(
  parameter int NUM_TAPS = 11
) (
  input  logic                clk,
  input  logic                rst,
  output logic [NUM_TAPS-1:0] taps
);
  localparam int CW = NUM_TAPS - 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + CW'(1);
  end

  assign taps[0] = ~rst;

  generate
    for (genvar k = 1; k < NUM_TAPS; k++) begin : g_tap
      assign taps[k] = ~rst & (cnt_q[k-1:0] == '0);
    end
  endgenerate
endmodule

// File: rtl/pwm_lin_div.sv
// Linear divider: counts pulses of the selected tap and emits one pulse every DIV of them.
module pwm_lin_div #(
  parameter int NUM_TAPS = 11,
  parameter int SEL_W    = 4,
  parameter int DIV_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_TAPS-1:0] taps,
  input  logic [SEL_W-1:0]    sel_in,
  input  logic [DIV_W-1:0]    div_in,
  output logic                pulse
);
  logic [SEL_W-1:0] sel_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;
  logic             chg;
  logic             tap_hit;
  logic             active;
  logic             last;

  // Any difference from the stored setting counts as a reconfiguration.
  assign chg = (sel_in != sel_q) | (div_in != div_q);

  // Reserved select codes match no tap and leave tap_hit low.
  always_comb begin
    tap_hit = 1'b0;
    for (int i = 0; i < NUM_TAPS; i++) begin
      if (sel_q == SEL_W'(i)) tap_hit = taps[i];
    end
  end

  assign active = (div_q != '0);
  assign last   = (cnt_q == div_q - DIV_W'(1));
  assign pulse  = ~rst & ~chg & active & tap_hit & last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      div_q <= '0;
      cnt_q <= '0;
    end else if (chg) begin
      sel_q <= sel_in;
      div_q <= div_in;
      cnt_q <= '0;
    end else if (active & tap_hit) begin
      cnt_q <= last ? '0 : cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/pwm_rate_gen.sv
module pwm_rate_gen
  import pwm_rate_pkg::*;
#(
  parameter int NUM_TAPS = PWM_TAPS,
  parameter int SEL_W    = PWM_SEL_W,
  parameter int DIV_W    = PWM_DIV_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SEL_W-1:0]    sel_a,
  input  logic [DIV_W-1:0]    div_a,
  input  logic [SEL_W-1:0]    sel_b,
  input  logic [DIV_W-1:0]    div_b,
  output logic [NUM_TAPS-1:0] tap_en,
  output logic                en_a,
  output logic                en_b
);
  localparam int NDIV = PWM_NDIV;

  logic [NDIV-1:0][SEL_W-1:0] sel_v;
  logic [NDIV-1:0][DIV_W-1:0] div_v;
  logic [NDIV-1:0]            en_v;

  assign sel_v[0] = sel_a;
  assign sel_v[1] = sel_b;
  assign div_v[0] = div_a;
  assign div_v[1] = div_b;
  assign en_a     = en_v[0];
  assign en_b     = en_v[1];

  pwm_tap_counter #(.NUM_TAPS(NUM_TAPS)) u_taps (
    .clk  (clk),
    .rst  (rst),
    .taps (tap_en)
  );

  generate
    for (genvar d = 0; d < NDIV; d++) begin : g_div
      pwm_lin_div #(
        .NUM_TAPS (NUM_TAPS),
        .SEL_W    (SEL_W),
        .DIV_W    (DIV_W)
      ) u_div (
        .clk    (clk),
        .rst    (rst),
        .taps   (tap_en),
        .sel_in (sel_v[d]),
        .div_in (div_v[d]),
        .pulse  (en_v[d])
      );
    end
  endgenerate
endmodule

// File: rtl/pwm_rate_gen_chk.sv
module pwm_rate_gen_chk #(
  parameter int NUM_TAPS = 11,
  parameter int SEL_W    = 4,
  parameter int DIV_W    = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [SEL_W-1:0]    sel_a,
  input logic [DIV_W-1:0]    div_a,
  input logic [SEL_W-1:0]    sel_b,
  input logic [DIV_W-1:0]    div_b,
  input logic [NUM_TAPS-1:0] tap_en,
  input logic                en_a,
  input logic                en_b
);
  assert_reset_quiet_R6: assert property (@(posedge clk)
    rst |-> (tap_en == '0 && !en_a && !en_b));

  assert_tap0_always_R1: assert property (@(posedge clk) disable iff (rst)
    tap_en[0]);

  assert_tap1_alternates_R1: assert property (@(posedge clk) disable iff (rst)
    tap_en[1] |=> !tap_en[1]);

  generate
    for (genvar k = 1; k < NUM_TAPS; k++) begin : g_nest
      assert_taps_nested_R2: assert property (@(posedge clk) disable iff (rst)
        tap_en[k] |-> tap_en[k-1]);
    end
  endgenerate

  assert_a_on_tap_R3: assert property (@(posedge clk) disable iff (rst)
    en_a |-> (sel_a < SEL_W'(NUM_TAPS) && ((tap_en >> sel_a) & 1) != 0));

  assert_b_on_tap_R3: assert property (@(posedge clk) disable iff (rst)
    en_b |-> (sel_b < SEL_W'(NUM_TAPS) && ((tap_en >> sel_b) & 1) != 0));

  assert_a_off_div0_R4: assert property (@(posedge clk) disable iff (rst)
    (div_a == '0) |-> !en_a);

  assert_b_off_div0_R4: assert property (@(posedge clk) disable iff (rst)
    (div_b == '0) |-> !en_b);

  assert_a_reserved_sel_R5: assert property (@(posedge clk) disable iff (rst)
    (sel_a >= SEL_W'(NUM_TAPS)) |-> !en_a);

  assert_b_reserved_sel_R5: assert property (@(posedge clk) disable iff (rst)
    (sel_b >= SEL_W'(NUM_TAPS)) |-> !en_b);

  assert_a_change_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (!$stable(div_a) || !$stable(sel_a)) |-> !en_a);
endmodule

bind pwm_rate_gen pwm_rate_gen_chk #(
  .NUM_TAPS (NUM_TAPS),
  .SEL_W    (SEL_W),
  .DIV_W    (DIV_W)
) u_chk (.*);

// File: tb/sim_pwm_rate_gen.sv
`timescale 1ns/1ps
module sim_pwm_rate_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  sel_a = '0, sel_b = '0;
  logic [7:0]  div_a = '0, div_b = '0;
  logic [10:0] tap_en;
  logic        en_a, en_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pwm_rate_gen u0 (
    .clk(clk), .rst(rst),
    .sel_a(sel_a), .div_a(div_a),
    .sel_b(sel_b), .div_b(div_b),
    .tap_en(tap_en), .en_a(en_a), .en_b(en_b)
  );

  // index 0..10: taps, 11: en_a, 12: en_b
  function automatic logic probe(int idx);
    if (idx < 11)       return tap_en[idx];
    else if (idx == 11) return en_a;
    else                return en_b;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic meas_period(int idx, int exp, string req);
    int gap;
    bit seen = 1'b0;
    for (int n = 0; n < 2 * exp + 8; n++) begin
      @(negedge clk);
      if (probe(idx)) begin seen = 1'b1; break; end
    end
    check(seen, {req, " first pulse"}, 0, 1);
    for (int r = 0; r < 2; r++) begin
      gap = 0;
      do begin
        @(negedge clk);
        gap++;
      end while (!probe(idx) && gap <= 2 * exp + 8);
      check(gap == exp, {req, " period"}, gap, exp);
    end
  endtask

  task automatic expect_silent(int idx, int cycles, string req);
    int hits = 0;
    for (int n = 0; n < cycles; n++) begin
      @(negedge clk);
      if (probe(idx)) hits++;
    end
    check(hits == 0, req, hits, 0);
  endtask

  task automatic t_reset;  // R6
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(tap_en == '0 && !en_a && !en_b, "R6 outputs low in reset",
          int'({tap_en, en_a, en_b}), 0);
    rst = 1'b0;
    #1;
    check(tap_en == 11'h7ff, "R6 all taps on first cycle", int'(tap_en), 'h7ff);
    check(!en_a && !en_b, "R6 dividers off after reset", int'({en_a, en_b}), 0);
  endtask

  task automatic t_taps;  // R1, R2
    meas_period(0, 1, "R1 tap0");
    meas_period(3, 8, "R1 tap3");
    meas_period(10, 1024, "R1 tap10");
    begin
      bit nested = 1'b1;
      for (int n = 0; n < 64; n++) begin
        @(negedge clk);
        for (int k = 1; k < 11; k++)
          if (tap_en[k] && !tap_en[k-1]) nested = 1'b0;
      end
      check(nested, "R2 taps nested", int'(nested), 1);
    end
  endtask

  task automatic t_divider;  // R3
    @(negedge clk); sel_a = 4'd0;  div_a = 8'd1;
    meas_period(11, 1, "R3 A sel0 div1");
    @(negedge clk); sel_a = 4'd0;  div_a = 8'd255;
    meas_period(11, 255, "R3 A sel0 div255");
    @(negedge clk); sel_a = 4'd3;  div_a = 8'd7;
    meas_period(11, 56, "R3 A sel3 div7");
    @(negedge clk); sel_a = 4'd10; div_a = 8'd1;
    meas_period(11, 1024, "R3 A sel10 div1");
  endtask

  task automatic t_off;  // R4, R5
    @(negedge clk); sel_a = 4'd0;  div_a = 8'd0;
    expect_silent(11, 300, "R4 A div0 silent");
    @(negedge clk); sel_b = 4'd2;  div_b = 8'd0;
    expect_silent(12, 300, "R4 B div0 silent");
    @(negedge clk); sel_a = 4'd12; div_a = 8'd1;
    expect_silent(11, 300, "R5 A sel12 silent");
    @(negedge clk); sel_b = 4'd15; div_b = 8'd3;
    expect_silent(12, 300, "R5 B sel15 silent");
  endtask

  task automatic t_change;  // R7
    int n;
    @(negedge clk); sel_a = 4'd0; div_a = 8'd3;
    repeat (20) @(negedge clk);
    div_a = 8'd5;
    #1;
    check(!en_a, "R7 no pulse in change cycle", int'(en_a), 0);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!en_a && n < 20);
    check(n == 5, "R7 first pulse after change", n, 5);
    meas_period(11, 5, "R7 steady after change");
  endtask

  task automatic t_indep;  // R8
    @(negedge clk);
    sel_a = 4'd1; div_a = 8'd3;
    sel_b = 4'd5; div_b = 8'd3;
    fork
      meas_period(11, 6, "R8 A alongside B");
      meas_period(12, 96, "R8 B alongside A");
    join
  endtask

  initial begin
    t_reset();
    t_taps();
    t_divider();
    t_off();
    t_change();
    t_indep();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule